// File: doc/BRIEF.md
# Multi-Policy Configuration Register Bank

A compact bank of four 32-bit registers, each field built to a fixed access policy: constant identity, live status, sticky status, read-to-set atomic flags, write-1-to-clear event bits, plain read/write control, a lock key, and lockable sticky write-1-to-clear event bits. Software reaches it through a synchronous port with a 2-bit word address, per-byte enables, write data and registered read data. Hardware reaches it through event inputs that set status bits.

Two resets are provided. The cold reset (active low) returns every field to its default. The warm reset (active low) returns only the non-sticky fields to their defaults. Sticky status, the lockable event bits and the lock key survive it.

Top module: `cfg_policy_bank`

## Requirements
- R1: Address 0 reads the constant parameter `ID_VALUE`; writes to it have no effect.
- R2: Address 1 bits [7:0] mirror `hw_status` at the cycle of the read; writes have no effect on them.
- R3: Address 1 bits [15:8] latch each `sticky_evt` bit high, ignore writes, keep their value through a warm reset and clear only on a cold reset.
- R4: Address 1 bits [31:24] are atomic flags. A read with `be[3]`=1 returns their value before the read and leaves all eight at 1. A read with `be[3]`=0 returns their current value and changes nothing.
- R5: A write to address 1 with `be[3]`=1 clears each flag whose `wdata` bit is 1. Zero bits, and writes with `be[3]`=0, leave the flags unchanged. A warm reset clears the flags.
- R6: Address 1 bits [23:16] are set by `w1c_evt` and cleared by writing 1 with `be[2]`=1. Writing 0 leaves a bit unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Address 2 bits [30:0] are read/write per enabled byte lane, change only by a write or reset, and return to 0 on a warm or cold reset.
- R8: Address 2 bit 31 is the lock key. A write of 1 with `be[3]`=1 sets it. A write of 0 does not clear it, and neither does a warm reset. Only a cold reset clears it.
- R9: Address 3 bits [7:0] are set by `lk_evt` and survive a warm reset. While the key is 0, writing 1 with `be[0]`=1 clears them. While the key is 1, clears are ignored but events still set them.
- R10: `rdata` updates one cycle after `rd_en` and otherwise holds, and reads 0 after either reset. When `rd_en` and `wr_en` are both high, the access is a read and the write is dropped. Unused bits of address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous, clears all fields |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous, clears non-sticky fields |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word address |
| be | input | 4 | Byte enables, bit n covers data bits [8n+7:8n] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| hw_status | input | 8 | Live status levels |
| sticky_evt | input | 8 | Sticky status set pulses |
| w1c_evt | input | 8 | Write-1-to-clear event set pulses |
| lk_evt | input | 8 | Lockable event set pulses |

## Verification
A hardware set of a write-1-to-clear bit and a software clear of that same bit can land in the same cycle. The bench provokes this by holding a `w1c_evt` bit and a byte-enabled write of 1 to that bit at the same clock edge. It then reads the register back and expects the bit still set. It also pairs a read strobe with a write strobe in one cycle, expecting the read to return the old value and a later read to show the write was dropped.

// File: rtl/cfg_policy_bank.sv
module cfg_policy_bank #(
  parameter logic [31:0] ID_VALUE = 32'h5A17_0C01
) (
  input  logic        clk,
  input  logic        cold_rst_n,
  input  logic        warm_rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [7:0]  hw_status,
  input  logic [7:0]  sticky_evt,
  input  logic [7:0]  w1c_evt,
  input  logic [7:0]  lk_evt
);
  logic [7:0]  stk_q, af_q, w1c_q, lk_q;
  logic [30:0] ctrl_q, ctrl_nx;
  logic        key_q;
  logic [31:0] rd_mux;

  wire wr   = wr_en & ~rd_en;
  wire sel1 = addr == 2'd1;
  wire sel2 = addr == 2'd2;
  wire sel3 = addr == 2'd3;

  wire       af_rd  = rd_en & sel1 & be[3];
  wire [7:0] af_clr = (wr & sel1 & be[3]) ? wdata[31:24] : 8'h00;
  wire [7:0] w_clr  = (wr & sel1 & be[2]) ? wdata[23:16] : 8'h00;
  wire [7:0] lk_clr = (wr & sel3 & be[0] & ~key_q) ? wdata[7:0] : 8'h00;
  wire       key_set = wr & sel2 & be[3] & wdata[31];

  always_comb begin
    ctrl_nx = ctrl_q;
    for (int b = 0; b < 4; b++)
      if (wr && sel2 && be[b])
        for (int i = 0; i < 8; i++)
          if (b * 8 + i < 31) ctrl_nx[b*8+i] = wdata[b*8+i];
  end

  always_comb begin
    case (addr)
      2'd0:    rd_mux = ID_VALUE;
      2'd1:    rd_mux = {af_q, w1c_q, stk_q, hw_status};
      2'd2:    rd_mux = {key_q, ctrl_q};
      default: rd_mux = {24'h0, lk_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      stk_q <= '0;
      lk_q  <= '0;
      key_q <= 1'b0;
    end else begin
      stk_q <= stk_q | sticky_evt;
      lk_q  <= (lk_q & ~lk_clr) | lk_evt;
      key_q <= key_q | key_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!cold_rst_n || !warm_rst_n) begin
      af_q   <= '0;
      w1c_q  <= '0;
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      af_q   <= af_rd ? 8'hFF : (af_q & ~af_clr);
      w1c_q  <= (w1c_q & ~w_clr) | w1c_evt;
      ctrl_q <= ctrl_nx;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

module cfg_policy_bank_chk (
  input logic        clk,
  input logic        cold_rst_n,
  input logic        warm_rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [3:0]  be,
  input logic [7:0]  sticky_evt,
  input logic [7:0]  w1c_evt,
  input logic [7:0]  stk_q,
  input logic [7:0]  af_q,
  input logic [7:0]  w1c_q,
  input logic [7:0]  lk_q,
  input logic [30:0] ctrl_q,
  input logic        key_q
);
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> stk_q == ($past(stk_q) | $past(sticky_evt)));

  assert_flag_set_on_read_R4: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (rd_en && addr == 2'd1 && be[3]) |=> af_q == 8'hFF);

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (w1c_evt != 8'h00) |=> (w1c_q & $past(w1c_evt)) == $past(w1c_evt));

  assert_ctrl_untouched_R7: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !(wr_en && !rd_en && addr == 2'd2) |=> $stable(ctrl_q));

  assert_key_holds_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    key_q |=> key_q);

  assert_locked_no_clear_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    key_q |=> (lk_q & $past(lk_q)) == $past(lk_q));
endmodule

bind cfg_policy_bank cfg_policy_bank_chk u_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be),
  .sticky_evt(sticky_evt), .w1c_evt(w1c_evt),
  .stk_q(stk_q), .af_q(af_q), .w1c_q(w1c_q), .lk_q(lk_q),
  .ctrl_q(ctrl_q), .key_q(key_q)
);

// File: tb/test_cfg_policy_bank.sv
module test_cfg_policy_bank;
  localparam logic [31:0] ID = 32'h5A17_0C01;

  logic        clk = 0, cold_rst_n = 0, warm_rst_n = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  hw_status = 0, sticky_evt = 0, w1c_evt = 0, lk_evt = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cfg_policy_bank #(.ID_VALUE(ID)) i_cfg_policy_bank (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
    .rdata(rdata), .hw_status(hw_status), .sticky_evt(sticky_evt),
    .w1c_evt(w1c_evt), .lk_evt(lk_evt)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  always begin
    @(posedge clk);
    if (rd_en) begin
      @(negedge clk);
      if (exp_q.size() == 0) check(rdata, 32'hx, "R10 unexpected read");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_rd(input logic [1:0] a, input logic [3:0] b, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; be = b; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_rst(input bit cold);
    @(negedge clk);
    warm_rst_n = 0;
    if (cold) cold_rst_n = 0;
    repeat (2) @(negedge clk);
    warm_rst_n = 1; cold_rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    hw_status = 8'hA5;
    repeat (3) @(negedge clk);
    check(rdata, 32'h0, "R10 rdata after cold reset");
    cold_rst_n = 1; warm_rst_n = 1;

    do_rd(0, 4'hF, ID, "R1 id value");
    do_wr(0, 4'hF, 32'hFFFF_FFFF);
    do_rd(0, 4'hF, ID, "R1 id after write");

    do_rd(1, 4'h7, 32'h0000_00A5, "R2 live status");
    do_wr(1, 4'h1, 32'h0000_0000);
    hw_status = 8'h3E;
    do_rd(1, 4'h7, 32'h0000_003E, "R2 live status follows input");
    hw_status = 8'hA5;

    @(negedge clk); sticky_evt = 8'h3C; @(negedge clk); sticky_evt = 0;
    do_wr(1, 4'h2, 32'h0000_FF00);
    do_rd(1, 4'h7, 32'h0000_3CA5, "R3 sticky latched, write ignored");

    do_rd(1, 4'h8, 32'h0000_3CA5, "R4 first enabled read returns 0");
    do_rd(1, 4'h8, 32'hFF00_3CA5, "R4 later enabled read returns 1");
    do_rd(1, 4'h7, 32'hFF00_3CA5, "R4 disabled read returns state");
    do_wr(1, 4'h8, 32'h0F00_0000);
    do_rd(1, 4'h7, 32'hF000_3CA5, "R5 write 1 clears flags");
    do_wr(1, 4'h7, 32'hFF00_0000);
    do_wr(1, 4'h8, 32'h0000_0000);
    do_rd(1, 4'h7, 32'hF000_3CA5, "R5 zero or disabled write no effect");
    do_wr(1, 4'hF, 32'h0000_0000);
    do_rd(1, 4'h7, 32'hF000_3CA5, "R5 full-lane zero write no effect");

    @(negedge clk); w1c_evt = 8'h81; @(negedge clk); w1c_evt = 0;
    do_rd(1, 4'h7, 32'hF081_3CA5, "R6 events set bits");
    do_wr(1, 4'h4, 32'h0001_0000);
    do_rd(1, 4'h7, 32'hF080_3CA5, "R6 write 1 clears bit");
    @(negedge clk);
    w1c_evt = 8'h80; addr = 1; be = 4'h4; wdata = 32'h0080_0000; wr_en = 1;
    @(negedge clk);
    w1c_evt = 0; wr_en = 0;
    do_rd(1, 4'h7, 32'hF080_3CA5, "R6 event beats same-cycle clear");
    do_wr(1, 4'h4, 32'h0000_0000);
    do_rd(1, 4'h7, 32'hF080_3CA5, "R6 write 0 no effect");
    do_wr(1, 4'h4, 32'h0080_0000);
    do_rd(1, 4'h7, 32'hF000_3CA5, "R6 clear after event");

    do_wr(2, 4'h5, 32'h1234_5678);
    do_rd(2, 4'hF, 32'h0034_0078, "R7 byte-lane write");
    @(negedge clk); w1c_evt = 8'hFF; sticky_evt = 8'hFF; @(negedge clk); w1c_evt = 0; sticky_evt = 0;
    do_rd(2, 4'hF, 32'h0034_0078, "R7 events do not touch control");
    do_wr(1, 4'h4, 32'h00FF_0000);

    do_rst(0);
    check(rdata, 32'h0, "R10 rdata after warm reset");
    do_rd(1, 4'h7, 32'h0000_FFA5, "R3 R5 warm reset keeps sticky, clears flags");
    do_rd(2, 4'hF, 32'h0000_0000, "R7 warm reset clears control");

    @(negedge clk); lk_evt = 8'h0F; @(negedge clk); lk_evt = 0;
    do_rd(3, 4'hF, 32'h0000_000F, "R9 events set lockable bits");
    do_wr(3, 4'h1, 32'h0000_0001);
    do_rd(3, 4'hF, 32'h0000_000E, "R9 unlocked clear");
    do_wr(2, 4'h8, 32'h8000_0000);
    do_rd(2, 4'hF, 32'h8000_0000, "R8 key set");
    do_wr(3, 4'h1, 32'h0000_000E);
    do_rd(3, 4'hF, 32'h0000_000E, "R9 locked clear ignored");
    @(negedge clk); lk_evt = 8'h10; @(negedge clk); lk_evt = 0;
    do_rd(3, 4'hF, 32'h0000_001E, "R9 locked event still sets");
    do_wr(2, 4'hF, 32'h0000_0000);
    do_rd(2, 4'hF, 32'h8000_0000, "R8 write 0 keeps key");
    do_rst(0);
    do_rd(2, 4'hF, 32'h8000_0000, "R8 key survives warm reset");
    do_rd(3, 4'hF, 32'h0000_001E, "R9 lockable survives warm reset");

    do_rst(1);
    check(rdata, 32'h0, "R10 rdata after cold reset");
    do_rd(2, 4'hF, 32'h0000_0000, "R8 cold reset clears key");
    do_rd(3, 4'hF, 32'h0000_0000, "R9 cold reset clears lockable");
    do_rd(1, 4'h7, 32'h0000_00A5, "R3 cold reset clears sticky");
    @(negedge clk); lk_evt = 8'h03; @(negedge clk); lk_evt = 0;
    do_wr(3, 4'h1, 32'h0000_0001);
    do_rd(3, 4'hF, 32'h0000_0002, "R9 clear works after lock released");

    @(negedge clk);
    exp_q.push_back(32'h0); tag_q.push_back("R10 read wins over write");
    addr = 2; be = 4'hF; wdata = 32'hFFFF_FFFF; rd_en = 1; wr_en = 1;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    do_rd(2, 4'hF, 32'h0000_0000, "R10 dropped write");
    repeat (3) @(negedge clk);
    check(rdata, 32'h0, "R10 rdata holds without read");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check(exp_q.size(), 0, "R10 reads outstanding");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule